// File: doc/BRIEF.md
# Lockable Partitioned Translation Buffer

This block is a fully associative translation buffer meant for processors with hard timing constraints. Each lookup presents a virtual page number and a context tag. The tag is the address-space identifier in normal mode and the virtual-machine identifier in virtualization mode. A hit returns the physical page number one cycle after the lookup is accepted. A miss issues a single refill request to an external page-table walker and holds off further lookups until the walker answers. The answer is then forwarded to the requester and installed in the buffer.

Software uses a control port to manage the entries. It can write a translation into a chosen entry and lock it there. It can unlock an entry, flush every unlocked entry, and enable or disable whole partitions. A locked entry is never chosen for replacement and survives a flush. Its lookups therefore always hit in one cycle while its partition is enabled. Entries in a disabled partition do not match, but they keep their contents until the partition is enabled again. Entries installed by a refill are unlocked and go into partition `FILL_PART`.

Top module: `lkp_tlb`

## Requirements
- R1: A translation written into any entry index, from 0 to ENTRIES-1, is found by a lookup whose key matches it.
- R2: An entry matches only when its VPN equals `lk_vpn` and its mode flag equals `lk_virt`. Its tag must also equal `lk_asid` when `lk_virt`=0, or `lk_vmid` when `lk_virt`=1.
- R3: A lookup accepted at edge N that hits gives `res_valid`=1, `res_hit`=1 and the stored `res_ppn` right after edge N+1 - 1, that is, in the cycle directly after acceptance. `lk_ready` stays 1.
- R4: A lookup that misses raises `walk_req_valid` in the next cycle, carrying the VPN, the mode and the selected tag. `lk_ready` stays 0 until `walk_rsp_valid` is seen. In the cycle after that, `res_valid`=1, `res_hit`=0 and `res_ppn` equals `walk_rsp_ppn`.
- R5: A refill is installed in the first unlocked entry at or after a round-robin pointer, and the pointer then moves past that entry. Locked entries are never overwritten by a refill. If every entry is locked, the refill is returned but not installed.
- R6: Control op 2 (flush) invalidates every unlocked entry. Locked entries keep matching afterwards.
- R7: Control op 1 (unlock) clears the lock of entry `ctl_idx`. The entry stays valid, but a later flush removes it.
- R8: Control op 3 loads the partition enable mask from `ctl_part_en`, with bit p enabling partition p. Entries in disabled partitions do not match. Their contents hit again once the partition is re-enabled.
- R9: After reset, all entries are invalid and all partitions are enabled. `lk_ready`=1, `walk_req_valid`=0 and `res_valid`=0.
- R10: Control op 0 (pin) writes the VPN, mode, tag, PPN and partition into entry `ctl_idx` and locks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_virt | input | 1 | 1 = virtualization mode (tag from lk_vmid) |
| lk_asid | input | ID_W | Address-space identifier |
| lk_vmid | input | ID_W | Virtual-machine identifier |
| lk_ready | output | 1 | Lookup can be accepted |
| res_valid | output | 1 | Translation result valid |
| res_hit | output | 1 | 1 = served from the buffer, 0 = served by refill |
| res_ppn | output | PPN_W | Physical page number |
| walk_req_valid | output | 1 | Refill request outstanding |
| walk_req_vpn | output | VPN_W | VPN to walk |
| walk_req_virt | output | 1 | Mode of the walked request |
| walk_req_id | output | ID_W | Tag of the walked request |
| walk_rsp_valid | input | 1 | Walker answer valid |
| walk_rsp_ppn | input | PPN_W | Walker physical page number |
| ctl_valid | input | 1 | Control command strobe |
| ctl_op | input | 2 | 0 pin, 1 unlock, 2 flush, 3 partition mask |
| ctl_idx | input | IDX_W | Target entry for pin/unlock |
| ctl_part | input | PART_W | Partition for pin |
| ctl_vpn | input | VPN_W | VPN for pin |
| ctl_virt | input | 1 | Mode flag for pin |
| ctl_id | input | ID_W | Tag for pin |
| ctl_ppn | input | PPN_W | PPN for pin |
| ctl_part_en | input | NPART | Partition enable mask |

## Verification
A corrupted lock or valid bit does not show up at once. It surfaces at the first refill that picks the wrong victim, or at the first flush. The next lookup to the lost page then produces a walker request instead of a one-cycle hit, and the returned PPN is the walker's value rather than the pinned one. A partition-gating fault shows one cycle after a lookup is accepted, as a hit where a miss is expected or the reverse. A stuck refill controller shows as `lk_ready` held low with no result ever appearing. The directed scenarios therefore pair each control command with lookups that tell a surviving pinned translation apart from a refilled one by its PPN.

// File: rtl/lkp_tlb_pkg.sv
package lkp_tlb_pkg;

   typedef enum logic [1:0] {
      CTL_PIN     = 2'd0,
      CTL_UNLOCK  = 2'd1,
      CTL_FLUSH   = 2'd2,
      CTL_PART_EN = 2'd3
   } ctl_op_e;

   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_WAIT = 1'b1
   } walk_state_e;

endpackage

// File: rtl/lkp_tlb_match.sv
module lkp_tlb_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int ID_W    = 8,
   parameter int NPART   = 4,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int PART_W = $clog2(NPART)
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] virt_vec,
   input  logic [PART_W-1:0]  ent_part [ENTRIES],
   input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
   input  logic [ID_W-1:0]    ent_id   [ENTRIES],
   input  logic [NPART-1:0]   part_en,
   input  logic [VPN_W-1:0]   key_vpn,
   input  logic               key_virt,
   input  logic [ID_W-1:0]    key_id,
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx
);

   logic [ENTRIES-1:0] line_hit;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign line_hit[g] = valid_vec[g]
                         && part_en[ent_part[g]]
                         && (virt_vec[g] == key_virt)
                         && (ent_vpn[g] == key_vpn)
                         && (ent_id[g] == key_id);
   end

   assign hit = |line_hit;

   // lowest matching index wins
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (line_hit[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/lkp_tlb_victim.sv
module lkp_tlb_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] lock_vec,
   input  logic               advance,
   output logic               found,
   output logic [IDX_W-1:0]   victim
);

   logic [IDX_W-1:0] rr_ptr;

   // first unlocked slot at or after the pointer, with wrap-around
   always_comb begin
      logic [IDX_W-1:0] cand;
      found  = 1'b0;
      victim = rr_ptr;
      for (int off = ENTRIES - 1; off >= 0; off--) begin
         cand = rr_ptr + IDX_W'(off);
         if (!lock_vec[cand]) begin
            found  = 1'b1;
            victim = cand;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_ptr <= '0;
      else if (advance)
         rr_ptr <= victim + IDX_W'(1);
   end

endmodule

// File: rtl/lkp_tlb_walkctl.sv
module lkp_tlb_walkctl
   import lkp_tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 16,
   parameter int ID_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic             lu_hit,
   input  logic [PPN_W-1:0] hit_ppn,
   input  logic [VPN_W-1:0] key_vpn,
   input  logic             key_virt,
   input  logic [ID_W-1:0]  key_id,
   input  logic             walk_rsp_valid,
   input  logic [PPN_W-1:0] walk_rsp_ppn,
   output logic             lk_ready,
   output logic             walk_req_valid,
   output logic [VPN_W-1:0] walk_req_vpn,
   output logic             walk_req_virt,
   output logic [ID_W-1:0]  walk_req_id,
   output logic             res_valid,
   output logic             res_hit,
   output logic [PPN_W-1:0] res_ppn,
   output logic             fill_en
);

   walk_state_e state;

   assign lk_ready       = (state == WS_IDLE);
   assign walk_req_valid = (state == WS_WAIT);
   assign fill_en        = (state == WS_WAIT) && walk_rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= WS_IDLE;
         res_valid     <= 1'b0;
         res_hit       <= 1'b0;
         res_ppn       <= '0;
         walk_req_vpn  <= '0;
         walk_req_virt <= 1'b0;
         walk_req_id   <= '0;
      end else begin
         res_valid <= 1'b0;
         unique case (state)
            WS_IDLE: begin
               if (lk_valid) begin
                  if (lu_hit) begin
                     res_valid <= 1'b1;
                     res_hit   <= 1'b1;
                     res_ppn   <= hit_ppn;
                  end else begin
                     state         <= WS_WAIT;
                     walk_req_vpn  <= key_vpn;
                     walk_req_virt <= key_virt;
                     walk_req_id   <= key_id;
                  end
               end
            end
            WS_WAIT: begin
               if (walk_rsp_valid) begin
                  state     <= WS_IDLE;
                  res_valid <= 1'b1;
                  res_hit   <= 1'b0;
                  res_ppn   <= walk_rsp_ppn;
               end
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lkp_tlb.sv
module lkp_tlb
   import lkp_tlb_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int VPN_W     = 20,
   parameter int PPN_W     = 16,
   parameter int ID_W      = 8,
   parameter int NPART     = 4,
   parameter int FILL_PART = 0,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int PART_W   = $clog2(NPART)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic               lk_virt,
   input  logic [ID_W-1:0]    lk_asid,
   input  logic [ID_W-1:0]    lk_vmid,
   output logic               lk_ready,
   output logic               res_valid,
   output logic               res_hit,
   output logic [PPN_W-1:0]   res_ppn,
   output logic               walk_req_valid,
   output logic [VPN_W-1:0]   walk_req_vpn,
   output logic               walk_req_virt,
   output logic [ID_W-1:0]    walk_req_id,
   input  logic               walk_rsp_valid,
   input  logic [PPN_W-1:0]   walk_rsp_ppn,
   input  logic               ctl_valid,
   input  logic [1:0]         ctl_op,
   input  logic [IDX_W-1:0]   ctl_idx,
   input  logic [PART_W-1:0]  ctl_part,
   input  logic [VPN_W-1:0]   ctl_vpn,
   input  logic               ctl_virt,
   input  logic [ID_W-1:0]    ctl_id,
   input  logic [PPN_W-1:0]   ctl_ppn,
   input  logic [NPART-1:0]   ctl_part_en
);

   // ---------------- elaboration checks ----------------
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("lkp_tlb: ENTRIES must be a power of two, at least 2");
   end
   if (NPART < 2 || (NPART & (NPART - 1)) != 0) begin : g_bad_npart
      $error("lkp_tlb: NPART must be a power of two, at least 2");
   end
   if (FILL_PART < 0 || FILL_PART >= NPART) begin : g_bad_fill
      $error("lkp_tlb: FILL_PART out of range");
   end
   if (VPN_W < 1 || PPN_W < 1 || ID_W < 1) begin : g_bad_width
      $error("lkp_tlb: field widths must be positive");
   end

   localparam logic [PART_W-1:0] FILL_P = PART_W'(FILL_PART);

   // ---------------- entry storage ----------------
   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] lock_vec;
   logic [ENTRIES-1:0] virt_vec;
   logic [PART_W-1:0]  ent_part [ENTRIES];
   logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
   logic [ID_W-1:0]    ent_id   [ENTRIES];
   logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
   logic [NPART-1:0]   part_en_q;

   // ---------------- lookup ----------------
   logic [ID_W-1:0]  key_id;
   logic             lu_hit;
   logic [IDX_W-1:0] hit_idx;
   logic             fill_en;
   logic             install_en;
   logic             victim_found;
   logic [IDX_W-1:0] victim_idx;
   ctl_op_e          op;

   assign key_id = lk_virt ? lk_vmid : lk_asid;
   assign op     = ctl_op_e'(ctl_op);

   lkp_tlb_match #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .ID_W    (ID_W),
      .NPART   (NPART)
   ) u_match (
      .valid_vec (valid_vec),
      .virt_vec  (virt_vec),
      .ent_part  (ent_part),
      .ent_vpn   (ent_vpn),
      .ent_id    (ent_id),
      .part_en   (part_en_q),
      .key_vpn   (lk_vpn),
      .key_virt  (lk_virt),
      .key_id    (key_id),
      .hit       (lu_hit),
      .hit_idx   (hit_idx)
   );

   lkp_tlb_walkctl #(
      .VPN_W (VPN_W),
      .PPN_W (PPN_W),
      .ID_W  (ID_W)
   ) u_walk (
      .clk            (clk),
      .rst_n          (rst_n),
      .lk_valid       (lk_valid),
      .lu_hit         (lu_hit),
      .hit_ppn        (ent_ppn[hit_idx]),
      .key_vpn        (lk_vpn),
      .key_virt       (lk_virt),
      .key_id         (key_id),
      .walk_rsp_valid (walk_rsp_valid),
      .walk_rsp_ppn   (walk_rsp_ppn),
      .lk_ready       (lk_ready),
      .walk_req_valid (walk_req_valid),
      .walk_req_vpn   (walk_req_vpn),
      .walk_req_virt  (walk_req_virt),
      .walk_req_id    (walk_req_id),
      .res_valid      (res_valid),
      .res_hit        (res_hit),
      .res_ppn        (res_ppn),
      .fill_en        (fill_en)
   );

   lkp_tlb_victim #(
      .ENTRIES (ENTRIES)
   ) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_vec (lock_vec),
      .advance  (install_en),
      .found    (victim_found),
      .victim   (victim_idx)
   );

   assign install_en = fill_en && victim_found;

   // ---------------- entry updates ----------------
   logic do_pin, do_unlock, do_flush;
   assign do_pin    = ctl_valid && (op == CTL_PIN);
   assign do_unlock = ctl_valid && (op == CTL_UNLOCK);
   assign do_flush  = ctl_valid && (op == CTL_FLUSH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_vec <= '0;
         lock_vec  <= '0;
         virt_vec  <= '0;
         part_en_q <= '1;
         for (int i = 0; i < ENTRIES; i++) begin
            ent_part[i] <= '0;
            ent_vpn[i]  <= '0;
            ent_id[i]   <= '0;
            ent_ppn[i]  <= '0;
         end
      end else begin
         if (ctl_valid && op == CTL_PART_EN) part_en_q <= ctl_part_en;
         for (int i = 0; i < ENTRIES; i++) begin
            if (do_flush && !lock_vec[i]) valid_vec[i] <= 1'b0;
            if (install_en && victim_idx == IDX_W'(i)) begin
               valid_vec[i] <= 1'b1;
               lock_vec[i]  <= 1'b0;
               virt_vec[i]  <= walk_req_virt;
               ent_part[i]  <= FILL_P;
               ent_vpn[i]   <= walk_req_vpn;
               ent_id[i]    <= walk_req_id;
               ent_ppn[i]   <= walk_rsp_ppn;
            end
            if (do_pin && ctl_idx == IDX_W'(i)) begin
               valid_vec[i] <= 1'b1;
               lock_vec[i]  <= 1'b1;
               virt_vec[i]  <= ctl_virt;
               ent_part[i]  <= ctl_part;
               ent_vpn[i]   <= ctl_vpn;
               ent_id[i]    <= ctl_id;
               ent_ppn[i]   <= ctl_ppn;
            end
            if (do_unlock && ctl_idx == IDX_W'(i)) lock_vec[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/lkp_tlb_chk.sv
module lkp_tlb_chk
   import lkp_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_ready,
   input logic               lu_hit,
   input logic               res_valid,
   input logic               res_hit,
   input logic [PPN_W-1:0]   res_ppn,
   input logic               walk_req_valid,
   input logic [VPN_W-1:0]   walk_req_vpn,
   input logic               walk_rsp_valid,
   input logic [PPN_W-1:0]   walk_rsp_ppn,
   input logic               ctl_valid,
   input logic [1:0]         ctl_op,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] lock_vec,
   input logic               install_en,
   input logic [IDX_W-1:0]   victim_idx
);

   AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready && lu_hit) |=> (res_valid && res_hit && lk_ready)); // R3

   AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready && !lu_hit) |=> (walk_req_valid && !res_valid && !lk_ready)); // R4

   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> !lk_ready); // R4

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn))); // R4

   AST_FILL_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && walk_rsp_valid) |=> (res_valid && !res_hit && res_ppn == $past(walk_rsp_ppn))); // R4

   AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      install_en |-> !lock_vec[victim_idx]); // R5

   AST_FLUSH_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && ctl_op == 2'(CTL_FLUSH)) |=> (($past(valid_vec & lock_vec) & ~valid_vec) == '0)); // R6

endmodule

bind lkp_tlb lkp_tlb_chk #(
   .ENTRIES (ENTRIES),
   .VPN_W   (VPN_W),
   .PPN_W   (PPN_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .lk_valid       (lk_valid),
   .lk_ready       (lk_ready),
   .lu_hit         (lu_hit),
   .res_valid      (res_valid),
   .res_hit        (res_hit),
   .res_ppn        (res_ppn),
   .walk_req_valid (walk_req_valid),
   .walk_req_vpn   (walk_req_vpn),
   .walk_rsp_valid (walk_rsp_valid),
   .walk_rsp_ppn   (walk_rsp_ppn),
   .ctl_valid      (ctl_valid),
   .ctl_op         (ctl_op),
   .valid_vec      (valid_vec),
   .lock_vec       (lock_vec),
   .install_en     (install_en),
   .victim_idx     (victim_idx)
);

// File: tb/sim_lkp_tlb.sv
`timescale 1ns/1ps
module sim_lkp_tlb;

   localparam int ENTRIES = 8;
   localparam int VPN_W   = 20;
   localparam int PPN_W   = 16;
   localparam int ID_W    = 8;
   localparam int NPART   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic             lk_valid = 0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic             lk_virt = 0;
   logic [ID_W-1:0]  lk_asid = '0, lk_vmid = '0;
   logic             lk_ready, res_valid, res_hit;
   logic [PPN_W-1:0] res_ppn;
   logic             walk_req_valid, walk_req_virt;
   logic [VPN_W-1:0] walk_req_vpn;
   logic [ID_W-1:0]  walk_req_id;
   logic             walk_rsp_valid = 0;
   logic [PPN_W-1:0] walk_rsp_ppn = '0;
   logic             ctl_valid = 0;
   logic [1:0]       ctl_op = '0;
   logic [2:0]       ctl_idx = '0;
   logic [1:0]       ctl_part = '0;
   logic [VPN_W-1:0] ctl_vpn = '0;
   logic             ctl_virt = 0;
   logic [ID_W-1:0]  ctl_id = '0;
   logic [PPN_W-1:0] ctl_ppn = '0;
   logic [NPART-1:0] ctl_part_en = '1;

   int n_chk = 0;
   int n_bad = 0;

   lkp_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ID_W(ID_W), .NPART(NPART)) u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_virt(lk_virt), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
      .lk_ready(lk_ready), .res_valid(res_valid), .res_hit(res_hit), .res_ppn(res_ppn),
      .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn), .walk_req_virt(walk_req_virt),
      .walk_req_id(walk_req_id), .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
      .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_idx(ctl_idx), .ctl_part(ctl_part),
      .ctl_vpn(ctl_vpn), .ctl_virt(ctl_virt), .ctl_id(ctl_id), .ctl_ppn(ctl_ppn),
      .ctl_part_en(ctl_part_en)
   );

   function automatic logic [PPN_W-1:0] wppn(input logic [VPN_W-1:0] v);
      return v[PPN_W-1:0] ^ 16'h5A5A;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one lookup; serves a miss with the walker model
   task automatic lookup(input logic [VPN_W-1:0] vpn, input logic virt,
                         input logic [ID_W-1:0] asid, input logic [ID_W-1:0] vmid,
                         output logic hit, output logic [PPN_W-1:0] ppn);
      logic [ID_W-1:0] tag;
      tag = virt ? vmid : asid;
      @(negedge clk);
      lk_valid = 1; lk_vpn = vpn; lk_virt = virt; lk_asid = asid; lk_vmid = vmid;
      @(posedge clk); #1;
      lk_valid = 0;
      if (res_valid) begin
         hit = res_hit; ppn = res_ppn;
         chk(res_hit == 1'b1, "R3", "hit flag on one-cycle result", 32'(res_hit), 1);
         chk(lk_ready == 1'b1, "R3", "ready after hit", 32'(lk_ready), 1);
      end else begin
         chk(walk_req_valid == 1'b1, "R4", "walk request raised", 32'(walk_req_valid), 1);
         chk(walk_req_vpn == vpn && walk_req_virt == virt && walk_req_id == tag, "R4",
             "walk request fields", 32'(walk_req_vpn), 32'(vpn));
         repeat (2) @(negedge clk);
         chk(lk_ready == 1'b0, "R4", "ready low while walking", 32'(lk_ready), 0);
         walk_rsp_valid = 1; walk_rsp_ppn = wppn(vpn);
         @(posedge clk); #1;
         walk_rsp_valid = 0;
         chk(res_valid && !res_hit, "R4", "refill result flags", {res_valid, res_hit}, 2'b10);
         chk(res_ppn == wppn(vpn), "R4", "refill ppn", 32'(res_ppn), 32'(wppn(vpn)));
         hit = 1'b0; ppn = res_ppn;
      end
   endtask

   task automatic expect_lu(input string req, input logic [VPN_W-1:0] vpn, input logic virt,
                            input logic [ID_W-1:0] asid, input logic [ID_W-1:0] vmid,
                            input logic exp_hit, input logic [PPN_W-1:0] exp_ppn);
      logic h;
      logic [PPN_W-1:0] p;
      lookup(vpn, virt, asid, vmid, h, p);
      chk(h == exp_hit, req, "hit/miss", 32'(h), 32'(exp_hit));
      chk(p == exp_ppn, req, "ppn", 32'(p), 32'(exp_ppn));
   endtask

   task automatic ctl(input logic [1:0] op, input int idx, input int part,
                      input logic [VPN_W-1:0] vpn, input logic virt,
                      input logic [ID_W-1:0] id, input logic [PPN_W-1:0] ppn,
                      input logic [NPART-1:0] mask);
      @(negedge clk);
      ctl_valid = 1; ctl_op = op; ctl_idx = 3'(idx); ctl_part = 2'(part);
      ctl_vpn = vpn; ctl_virt = virt; ctl_id = id; ctl_ppn = ppn; ctl_part_en = mask;
      @(posedge clk); #1;
      ctl_valid = 0;
   endtask

   task automatic pin(input int idx, input int part, input logic [VPN_W-1:0] vpn,
                      input logic virt, input logic [ID_W-1:0] id, input logic [PPN_W-1:0] ppn);
      ctl(2'd0, idx, part, vpn, virt, id, ppn, '1);
   endtask

   task automatic t_reset;
      chk(lk_ready == 1'b1, "R9", "ready after reset", 32'(lk_ready), 1);
      chk(walk_req_valid == 1'b0, "R9", "no walk after reset", 32'(walk_req_valid), 0);
      chk(res_valid == 1'b0, "R9", "no result after reset", 32'(res_valid), 0);
      expect_lu("R9", 20'h00100, 0, 8'd1, 8'd0, 0, wppn(20'h00100));
   endtask

   task automatic t_refill_then_hit;
      expect_lu("R5", 20'h00100, 0, 8'd1, 8'd0, 1, wppn(20'h00100));
   endtask

   task automatic t_key_match;
      pin(7, 1, 20'h00200, 0, 8'd5, 16'hC007);
      pin(0, 1, 20'h00300, 1, 8'd9, 16'hC000);
      expect_lu("R1", 20'h00200, 0, 8'd5, 8'h77, 1, 16'hC007);
      expect_lu("R10", 20'h00300, 1, 8'h22, 8'd9, 1, 16'hC000);
      expect_lu("R2", 20'h00200, 0, 8'd6, 8'd5, 0, wppn(20'h00200));
      expect_lu("R2", 20'h00300, 0, 8'd9, 8'd9, 0, wppn(20'h00300));
      expect_lu("R2", 20'h00200, 1, 8'd5, 8'h44, 0, wppn(20'h00200));
   endtask

   task automatic t_partition;
      pin(4, 2, 20'h00400, 0, 8'd1, 16'hC004);
      ctl(2'd3, 0, 0, '0, 0, '0, '0, 4'b1011);
      expect_lu("R8", 20'h00400, 0, 8'd1, 8'd0, 0, wppn(20'h00400));
      expect_lu("R8", 20'h00400, 0, 8'd1, 8'd0, 1, wppn(20'h00400));
      ctl(2'd2, 0, 0, '0, 0, '0, '0, '1);
      ctl(2'd3, 0, 0, '0, 0, '0, '0, 4'b1111);
      expect_lu("R8", 20'h00400, 0, 8'd1, 8'd0, 1, 16'hC004);
   endtask

   task automatic t_flush;
      expect_lu("R6", 20'h00500, 0, 8'd1, 8'd0, 0, wppn(20'h00500));
      expect_lu("R6", 20'h00500, 0, 8'd1, 8'd0, 1, wppn(20'h00500));
      ctl(2'd2, 0, 0, '0, 0, '0, '0, '1);
      expect_lu("R6", 20'h00500, 0, 8'd1, 8'd0, 0, wppn(20'h00500));
      expect_lu("R6", 20'h00200, 0, 8'd5, 8'd0, 1, 16'hC007);
   endtask

   task automatic t_unlock;
      ctl(2'd1, 7, 0, '0, 0, '0, '0, '1);
      expect_lu("R7", 20'h00200, 0, 8'd5, 8'd0, 1, 16'hC007);
      ctl(2'd2, 0, 0, '0, 0, '0, '0, '1);
      expect_lu("R7", 20'h00200, 0, 8'd5, 8'd0, 0, wppn(20'h00200));
   endtask

   task automatic t_all_locked_and_rr;
      for (int i = 0; i < ENTRIES; i++)
         pin(i, 0, 20'h00800 + VPN_W'(i), 0, 8'd3, 16'hC100 + PPN_W'(i));
      expect_lu("R5", 20'h00900, 0, 8'd3, 8'd0, 0, wppn(20'h00900));
      expect_lu("R5", 20'h00900, 0, 8'd3, 8'd0, 0, wppn(20'h00900));
      expect_lu("R5", 20'h00805, 0, 8'd3, 8'd0, 1, 16'hC105);
      ctl(2'd1, 1, 0, '0, 0, '0, '0, '1);
      ctl(2'd1, 6, 0, '0, 0, '0, '0, '1);
      expect_lu("R5", 20'h00A00, 0, 8'd3, 8'd0, 0, wppn(20'h00A00));
      expect_lu("R5", 20'h00A01, 0, 8'd3, 8'd0, 0, wppn(20'h00A01));
      expect_lu("R5", 20'h00A00, 0, 8'd3, 8'd0, 1, wppn(20'h00A00));
      expect_lu("R5", 20'h00A01, 0, 8'd3, 8'd0, 1, wppn(20'h00A01));
      expect_lu("R5", 20'h00802, 0, 8'd3, 8'd0, 1, 16'hC102);
      expect_lu("R1", 20'h00807, 0, 8'd3, 8'd0, 1, 16'hC107);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_refill_then_hit;
      t_key_match;
      t_partition;
      t_flush;
      t_unlock;
      t_all_locked_and_rr;
      repeat (3) @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule